// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a virtual address when the translation cache misses. It reads two levels of page table from word-addressed memory. The virtual address is cut into three fields: a master index, a secondary index and a page offset. The master index selects one word in the master table. That word supplies the base of a secondary table. The secondary index then selects the final page table entry. The entry that comes back is meant for loading into the translation cache, after which translation resumes. A missing secondary table ends the walk with a fault, and so does a page that is not present. The two faults carry distinct level codes.

The memory side is a plain request/response port. The walker pulses a request with an address for one cycle. The memory answers with a data-valid strobe after any number of cycles, without backpressure. The table layout is fixed:

- Each entry is 32 bits.
- Bits 31:12 hold the frame number.
- Bits 3:1 hold the access rights.
- Bit 0 marks the entry present.

The walker accepts a new walk only while it is idle. Each walk ends with a single-cycle completion strobe.

Top module: `pt_walker`

## Requirements
- R1: The master index is `walk_vaddr[31:22]`. The first memory read goes to `root_base + 4 * master_index`. Both the address and the base are captured in the cycle the request is accepted, so later changes to either input have no effect on the walk in progress.
- R2: The secondary index is `walk_vaddr[21:12]`. The second read goes to `{master_entry[31:12], 12'h000} + 4 * secondary_index`.
- R3: An entry is present when its bit 0 is 1. If the master entry is not present, the walk completes with `fault=1` and `fault_level=1`. No second read is made, and `result_pte` carries the master entry as read.
- R4: If the secondary entry is not present, the walk completes with `fault=1` and `fault_level=2`. `result_pte` carries the secondary entry as read.
- R5: If the secondary entry is present, the walk completes with `fault=0` and `fault_level=0`. `result_pte` equals all 32 bits of the secondary entry, including the frame number and the access bits 3:1.
- R6: `done` is high for exactly one cycle. It rises in the cycle after the edge that captures the response ending the walk.
- R7: `walk_ready` is high only in the idle state. `walk_req` is accepted only there. A request raised during a walk is ignored and starts no later walk.
- R8: `mem_req` is a one-cycle pulse per table read, and is never raised while idle. A `mem_rvalid` arriving when no response is awaited is ignored.
- R9: While reset is asserted and after it is released, the block is idle with `walk_ready=1`. In that state `mem_req=0`, `done=0`, `fault=0`, `fault_level=0` and `result_pte=0`. A reset in mid-walk aborts the walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| walk_req | input | 1 | Request to start a walk |
| walk_vaddr | input | 32 | Virtual address to resolve |
| root_base | input | 32 | Byte address of the master table |
| walk_ready | output | 1 | Walker idle and able to accept a request |
| mem_req | output | 1 | One-cycle memory read request |
| mem_addr | output | 32 | Byte address of the entry being read |
| mem_rvalid | input | 1 | Read data valid strobe |
| mem_rdata | input | 32 | Read data (table entry) |
| done | output | 1 | One-cycle walk completion strobe |
| result_pte | output | 32 | Last entry read by the walk |
| fault | output | 1 | Walk ended without a translation |
| fault_level | output | 2 | 0 none, 1 master entry absent, 2 page absent |

## Verification
The walker's cycle timing is fixed, so the bench checks each result in the cycle it is due:

- **First read.** After an accepted request, `mem_req` and the master-entry address appear one cycle later.
- **Second read.** After the master response edge, either the secondary read request or `done` appears one cycle later.
- **Completion.** After the secondary response edge, `done` with its result appears one cycle later. `done` must be gone on the following cycle.

The bench drives inputs and samples outputs on the falling edge. It counts the cycles of each response latency itself, so every check lands exactly on the cycle the requirements predict. Between responses it keeps raising requests and changing inputs, so ignored stimulus would show up at once in the next address or result.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  localparam int unsigned WORD_W      = 32;
  localparam int unsigned ENTRY_SHIFT = 2;

  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_MASTER,
    ST_WT_MASTER,
    ST_RD_SECOND,
    ST_WT_SECOND,
    ST_FINISH
  } walk_state_e;

  typedef enum logic [1:0] {
    LVL_NONE   = 2'd0,
    LVL_MASTER = 2'd1,
    LVL_SECOND = 2'd2
  } fault_lvl_e;

  // Byte address of entry number idx in a table starting at base.
  function automatic word_t entry_addr(input word_t base, input word_t idx);
    return base + (idx << ENTRY_SHIFT);
  endfunction

  // Page-aligned table base carried by an entry.
  function automatic word_t frame_base(input word_t entry, input int unsigned off_bits);
    return (entry >> off_bits) << off_bits;
  endfunction

  function automatic logic entry_present(input word_t entry);
    return entry[0];
  endfunction

endpackage

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import ptw_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic rvalid,
  input  logic entry_ok,
  output logic ready,
  output logic accept,
  output logic issue_master,
  output logic issue_second,
  output logic cap_master,
  output logic cap_second,
  output logic walk_end,
  output logic done
);

  walk_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:      if (start) state_d = ST_RD_MASTER;
      ST_RD_MASTER: state_d = ST_WT_MASTER;
      ST_WT_MASTER: if (rvalid) state_d = entry_ok ? ST_RD_SECOND : ST_FINISH;
      ST_RD_SECOND: state_d = ST_WT_SECOND;
      ST_WT_SECOND: if (rvalid) state_d = ST_FINISH;
      ST_FINISH:    state_d = ST_IDLE;
      default:      state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign ready        = (state_q == ST_IDLE);
  assign accept       = ready && start;
  assign issue_master = (state_q == ST_RD_MASTER);
  assign issue_second = (state_q == ST_RD_SECOND);
  assign cap_master   = (state_q == ST_WT_MASTER) && rvalid;
  assign cap_second   = (state_q == ST_WT_SECOND) && rvalid;
  assign walk_end     = (cap_master && !entry_ok) || cap_second;
  assign done         = (state_q == ST_FINISH);

endmodule

// File: rtl/ptw_addr_path.sv
module ptw_addr_path
  import ptw_pkg::*;
#(
  parameter int unsigned VA_W      = 32,
  parameter int unsigned L1_BITS   = 10,
  parameter int unsigned L2_BITS   = 10,
  parameter int unsigned OFF_BITS  = VA_W - L1_BITS - L2_BITS
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        accept,
  input  logic [VA_W-1:0] vaddr,
  input  word_t       root_base,
  input  logic        cap_master,
  input  word_t       rdata,
  input  logic        sel_second,
  output word_t       addr
);

  localparam int unsigned IDX_HI = VA_W - 1;

  logic [L1_BITS-1:0] master_idx_q;
  logic [L2_BITS-1:0] second_idx_q;
  word_t              root_q;
  word_t              second_base_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      master_idx_q  <= '0;
      second_idx_q  <= '0;
      root_q        <= '0;
      second_base_q <= '0;
    end else begin
      if (accept) begin
        master_idx_q <= vaddr[IDX_HI -: L1_BITS];
        second_idx_q <= vaddr[IDX_HI-L1_BITS -: L2_BITS];
        root_q       <= root_base;
      end
      if (cap_master) second_base_q <= frame_base(rdata, OFF_BITS);
    end
  end

  word_t master_addr;
  word_t second_addr;

  assign master_addr = entry_addr(root_q, word_t'(master_idx_q));
  assign second_addr = entry_addr(second_base_q, word_t'(second_idx_q));
  assign addr        = sel_second ? second_addr : master_addr;

endmodule

// File: rtl/ptw_result.sv
module ptw_result
  import ptw_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cap_master,
  input  logic       cap_second,
  input  logic       entry_ok,
  input  word_t      rdata,
  output word_t      pte,
  output logic       fault,
  output logic [1:0] level
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pte   <= '0;
      fault <= 1'b0;
      level <= LVL_NONE;
    end else if (cap_master && !entry_ok) begin
      pte   <= rdata;
      fault <= 1'b1;
      level <= LVL_MASTER;
    end else if (cap_second) begin
      pte   <= rdata;
      fault <= !entry_ok;
      level <= entry_ok ? LVL_NONE : LVL_SECOND;
    end
  end

endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
#(
  parameter int unsigned VA_W    = 32,
  parameter int unsigned L1_BITS = 10,
  parameter int unsigned L2_BITS = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            walk_req,
  input  logic [VA_W-1:0] walk_vaddr,
  input  logic [31:0]     root_base,
  output logic            walk_ready,
  output logic            mem_req,
  output logic [31:0]     mem_addr,
  input  logic            mem_rvalid,
  input  logic [31:0]     mem_rdata,
  output logic            done,
  output logic [31:0]     result_pte,
  output logic            fault,
  output logic [1:0]      fault_level
);

  localparam int unsigned OFF_BITS = VA_W - L1_BITS - L2_BITS;

  // Named internal events, observed by the bound checker.
  logic walk_accept;
  logic issue_master;
  logic issue_second;
  logic cap_master;
  logic cap_second;
  logic walk_end;
  logic entry_ok;

  assign entry_ok = entry_present(mem_rdata);

  ptw_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (walk_req),
    .rvalid       (mem_rvalid),
    .entry_ok     (entry_ok),
    .ready        (walk_ready),
    .accept       (walk_accept),
    .issue_master (issue_master),
    .issue_second (issue_second),
    .cap_master   (cap_master),
    .cap_second   (cap_second),
    .walk_end     (walk_end),
    .done         (done)
  );

  ptw_addr_path #(
    .VA_W     (VA_W),
    .L1_BITS  (L1_BITS),
    .L2_BITS  (L2_BITS),
    .OFF_BITS (OFF_BITS)
  ) u_addr (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (walk_accept),
    .vaddr      (walk_vaddr),
    .root_base  (root_base),
    .cap_master (cap_master),
    .rdata      (mem_rdata),
    .sel_second (issue_second),
    .addr       (mem_addr)
  );

  ptw_result u_result (
    .clk        (clk),
    .rst_n      (rst_n),
    .cap_master (cap_master),
    .cap_second (cap_second),
    .entry_ok   (entry_ok),
    .rdata      (mem_rdata),
    .pte        (result_pte),
    .fault      (fault),
    .level      (fault_level)
  );

  assign mem_req = issue_master || issue_second;

endmodule

// File: rtl/ptw_checker.sv
module ptw_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        accept,
  input logic        ready,
  input logic        mem_req,
  input logic        walk_end,
  input logic        done,
  input logic        fault,
  input logic [1:0]  fault_level,
  input logic [31:0] result_pte
);

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6
  end_to_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    walk_end |=> done);

  // R8
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);

  // R8
  req_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !ready);

  // R7
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !ready);

  // R3
  fault_vs_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (fault == !result_pte[0]));

  // R4
  fault_level_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault) |-> (fault_level == 2'd1 || fault_level == 2'd2));

  // R5
  ok_level_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !fault) |-> (fault_level == 2'd0));

endmodule

bind pt_walker ptw_checker u_ptw_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .accept      (walk_accept),
  .ready       (walk_ready),
  .mem_req     (mem_req),
  .walk_end    (walk_end),
  .done        (done),
  .fault       (fault),
  .fault_level (fault_level),
  .result_pte  (result_pte)
);

// File: tb/pt_walker_bench.sv
module pt_walker_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 20000;

  typedef struct packed {
    logic [31:0] va;
    logic [31:0] base;
    logic [31:0] d1;
    logic [31:0] d2;
    logic [3:0]  lat1;
    logic [3:0]  lat2;
    logic        efault;
    logic [1:0]  elvl;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_7468, 32'h0001_0000, 32'h0002_0001, 32'h0000_2007, 4'd1, 4'd1, 1'b0, 2'd0},
    '{32'hFFFF_FFFF, 32'h0040_0000, 32'h00AB_C00F, 32'h1234_500B, 4'd3, 4'd0, 1'b0, 2'd0},
    '{32'h0040_1000, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 4'd2, 4'd0, 1'b1, 2'd1},
    '{32'h8000_3ABC, 32'h0010_0000, 32'h0055_5001, 32'h0066_600E, 4'd0, 4'd4, 1'b1, 2'd2},
    '{32'h0000_0000, 32'hFFFF_F000, 32'hFFFF_F001, 32'h0000_1003, 4'd5, 4'd2, 1'b0, 2'd0},
    '{32'h1234_5678, 32'h0000_8000, 32'h0000_9FFE, 32'h0000_0000, 4'd0, 4'd0, 1'b1, 2'd1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        walk_req = 1'b0;
  logic [31:0] walk_vaddr = '0;
  logic [31:0] root_base = '0;
  logic        walk_ready;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        done;
  logic [31:0] result_pte;
  logic        fault;
  logic [1:0]  fault_level;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pt_walker u_pt_walker (
    .clk         (clk),
    .rst_n       (rst_n),
    .walk_req    (walk_req),
    .walk_vaddr  (walk_vaddr),
    .root_base   (root_base),
    .walk_ready  (walk_ready),
    .mem_req     (mem_req),
    .mem_addr    (mem_addr),
    .mem_rvalid  (mem_rvalid),
    .mem_rdata   (mem_rdata),
    .done        (done),
    .result_pte  (result_pte),
    .fault       (fault),
    .fault_level (fault_level)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Bench's own view of the table arithmetic.
  function automatic logic [31:0] exp_master_addr(input logic [31:0] va, input logic [31:0] b);
    return b + {20'd0, va[31:22], 2'b00};
  endfunction

  function automatic logic [31:0] exp_second_addr(input logic [31:0] va, input logic [31:0] e);
    return {e[31:12], 12'h000} + {20'd0, va[21:12], 2'b00};
  endfunction

  task automatic run_walk(input vec_t v, input bit glitch);
    @(negedge clk);
    chk("R7", "ready before walk", {31'd0, walk_ready}, 32'd1);
    walk_req   = 1'b1;
    walk_vaddr = v.va;
    root_base  = v.base;
    @(negedge clk);
    walk_req   = 1'b0;
    walk_vaddr = ~v.va;
    root_base  = v.base ^ 32'h5A5A_0000;
    // master read issued one cycle after acceptance
    chk("R1", "first mem_req", {31'd0, mem_req}, 32'd1);
    chk("R1", "master address", mem_addr, exp_master_addr(v.va, v.base));
    chk("R7", "ready low in walk", {31'd0, walk_ready}, 32'd0);
    if (glitch) begin
      mem_rvalid = 1'b1;
      mem_rdata  = 32'h0000_0000;
    end
    @(negedge clk);
    mem_rvalid = 1'b0;
    chk("R8", "single request pulse", {31'd0, mem_req}, 32'd0);
    for (int i = 0; i < int'(v.lat1); i++) begin
      walk_req = 1'b1;
      @(negedge clk);
      walk_req = 1'b0;
    end
    mem_rvalid = 1'b1;
    mem_rdata  = v.d1;
    @(negedge clk);
    mem_rvalid = 1'b0;
    mem_rdata  = 32'hDEAD_BEEF;
    if (!(v.efault && v.elvl == 2'd1)) begin
      chk("R2", "second mem_req", {31'd0, mem_req}, 32'd1);
      chk("R2", "secondary address", mem_addr, exp_second_addr(v.va, v.d1));
      chk("R6", "no early done", {31'd0, done}, 32'd0);
      @(negedge clk);
      for (int i = 0; i < int'(v.lat2); i++) begin
        walk_req = 1'b1;
        @(negedge clk);
        walk_req = 1'b0;
      end
      mem_rvalid = 1'b1;
      mem_rdata  = v.d2;
      @(negedge clk);
      mem_rvalid = 1'b0;
      mem_rdata  = 32'hDEAD_BEEF;
    end else begin
      chk("R3", "no second read", {31'd0, mem_req}, 32'd0);
    end
    chk("R6", "done due", {31'd0, done}, 32'd1);
    if (v.efault && v.elvl == 2'd1) begin
      chk("R3", "fault", {31'd0, fault}, 32'd1);
      chk("R3", "fault_level", {30'd0, fault_level}, 32'd1);
      chk("R3", "result_pte", result_pte, v.d1);
    end else if (v.efault) begin
      chk("R4", "fault", {31'd0, fault}, 32'd1);
      chk("R4", "fault_level", {30'd0, fault_level}, 32'd2);
      chk("R4", "result_pte", result_pte, v.d2);
    end else begin
      chk("R5", "fault", {31'd0, fault}, 32'd0);
      chk("R5", "fault_level", {30'd0, fault_level}, 32'd0);
      chk("R5", "result_pte", result_pte, v.d2);
    end
    @(negedge clk);
    chk("R6", "done one cycle", {31'd0, done}, 32'd0);
    chk("R7", "idle after walk", {31'd0, walk_ready}, 32'd1);
    chk("R7", "no stray walk", {31'd0, mem_req}, 32'd0);
  endtask

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    failures++;
    $display("FAIL R6 watchdog actual=hung expected=walk_completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R9 reset state
    repeat (3) @(negedge clk);
    chk("R9", "ready in reset", {31'd0, walk_ready}, 32'd1);
    chk("R9", "mem_req in reset", {31'd0, mem_req}, 32'd0);
    chk("R9", "done in reset", {31'd0, done}, 32'd0);
    chk("R9", "fault in reset", {31'd0, fault}, 32'd0);
    chk("R9", "level in reset", {30'd0, fault_level}, 32'd0);
    chk("R9", "pte in reset", result_pte, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9", "ready after reset", {31'd0, walk_ready}, 32'd1);

    for (int k = 0; k < NV; k++) run_walk(VECS[k], 1'b0);

    // R8 response while idle is ignored
    @(negedge clk);
    mem_rvalid = 1'b1;
    mem_rdata  = 32'h0000_0001;
    @(negedge clk);
    mem_rvalid = 1'b0;
    chk("R8", "idle rvalid no done", {31'd0, done}, 32'd0);
    chk("R8", "idle rvalid no req", {31'd0, mem_req}, 32'd0);
    chk("R8", "idle rvalid ready", {31'd0, walk_ready}, 32'd1);

    // R8 response during the request cycle is ignored
    run_walk(VECS[0], 1'b1);

    // R9 reset in mid-walk
    @(negedge clk);
    walk_req   = 1'b1;
    walk_vaddr = VECS[1].va;
    root_base  = VECS[1].base;
    @(negedge clk);
    walk_req = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R9", "abort ready", {31'd0, walk_ready}, 32'd1);
    chk("R9", "abort no req", {31'd0, mem_req}, 32'd0);
    chk("R9", "abort no done", {31'd0, done}, 32'd0);
    rst_n = 1'b1;
    run_walk(VECS[3], 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule